// File: doc/BRIEF.md
# Dual-Mode Reloadable Interval Timer

This block is a 16-bit down-counting interval timer that sits on an 8-bit processor register bus. Software writes a reload value into a write-only latch through two byte addresses. It reads the live counter back through the same addresses, and it steers the timer through an 8-bit control register. The counter decrements on a selectable tick source. One source is every system clock cycle. Another is each rising edge of an asynchronous external count input, which is synchronized and edge-detected first. When the cascade variant is built in, two more sources exist: underflows of a companion timer, either always or only while the external input is high.

An underflow happens when a tick arrives while the counter holds zero. On an underflow the counter reloads from the latch. Continuous mode then keeps counting. One-shot mode stops, and its start bit clears itself. Each underflow produces a same-cycle strobe for cascading into another timer or a serial shifter. It also produces a registered one-cycle interrupt request for an external interrupt collector, and a port-pin output in pulse or toggle form. That output is gated by an enable bit. The block has no streaming data path. All pins are plain control and status signals, and register accesses complete in the cycle they are presented, with no back-pressure.

Top module: `interval_timer`

## Requirements
- R1: Reset clears the control register to 0x00, sets the reload latch and the counter to 0xFFFF, and drives irq, pb_oe and pb_val low.
- R2: Register addresses are 0 = low byte, 1 = high byte, 2 = control; address 3 reads 0. A write to address 0 or 1 updates the matching latch byte; reads of 0 and 1 return the live counter bytes, and a low-byte write never changes the counter.
- R3: A high-byte write while the timer is stopped (control bit 0 = 0) also loads the counter with {written byte, latch low byte}. While it runs in continuous mode, that write changes only the latch.
- R4: Control bit 4 is a load strobe. Writing it as 1 copies the latch into the counter in any state, writing it as 0 leaves the counter alone, and it always reads back as 0.
- R5: While control bit 0 is 1 and the source is the system clock (bits 6:5 = 00), the counter drops by one every cycle. While bit 0 is 0, the counter holds its value.
- R6: A tick that arrives while the counter is zero is an underflow. uf_strobe is high in that same cycle, and at the next edge the counter reloads the latch. In continuous mode (bit 3 = 0) counting goes on, giving one underflow per latch+1 ticks.
- R7: In one-shot mode (bit 3 = 1) an underflow reloads the counter and clears control bit 0, so the counter then holds the latch value.
- R8: In one-shot mode a high-byte write loads the counter from the latch and sets control bit 0, whatever bit 0 held before.
- R9: irq is high for exactly the one cycle following each underflow cycle.
- R10: pb_oe equals control bit 1, and pb_val is 0 while bit 1 is 0. In pulse form (bit 2 = 0), pb_val equals irq. In toggle form (bit 2 = 1), pb_val inverts at each underflow, goes high when the timer goes from stopped to started, and is low after reset.
- R11: With bits 6:5 = 01, each rising edge of ext_cnt gives one tick after a two-stage synchronizer. A steady level gives no ticks.
- R12: With bits 6:5 = 10, each casc_uf cycle is a tick. With 11, a casc_uf cycle is a tick only while the synchronized ext_cnt is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address (0 low, 1 high, 2 control) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle, 0 when not reading |
| ext_cnt | input | 1 | Asynchronous external count input |
| casc_uf | input | 1 | Companion timer underflow strobe |
| uf_strobe | output | 1 | Same-cycle underflow strobe for cascading |
| irq | output | 1 | One-cycle interrupt request after an underflow |
| pb_oe | output | 1 | Port-pin output enable |
| pb_val | output | 1 | Port-pin output value (pulse or toggle) |

## Verification
The counting function is run in four input patterns: free-running system-clock ticks, external edges separated by long steady levels, single-cycle companion strobes, and companion strobes gated by the external level. Each pattern lets the bench check a different source decode. Steady external levels with an unchanged counter separate level counting from edge counting. Companion strobes given once with ext_cnt low and once with it high separate mode 10 from mode 11. A short reload value, tracked cycle by cycle against a reference counter, separates an off-by-one reload period from a correct one. Stopped, running-continuous and one-shot high-byte writes separate the three reload rules from one another.

// File: rtl/it_pkg.sv
package it_pkg;
  localparam int CTRL_W = 8;
  localparam int CB_START   = 0;
  localparam int CB_PBEN    = 1;
  localparam int CB_TOGGLE  = 2;
  localparam int CB_ONESHOT = 3;
  localparam int CB_LOAD    = 4;
  localparam int CB_SRC_LO  = 5;
  localparam int CB_SRC_HI  = 6;

  typedef enum logic [1:0] {
    SRC_SYS        = 2'b00,
    SRC_EXT        = 2'b01,
    SRC_CASC       = 2'b10,
    SRC_CASC_GATED = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_e;
endpackage

// File: rtl/it_tick_src.sv
module it_tick_src
  import it_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_CASCADE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_in,
  input  logic       casc_in,
  input  logic [1:0] src_sel,
  output logic       tick
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   ext_lvl;
  logic                   ext_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], ext_in};
      last_q <= sync_q[MSB];
    end
  end

  assign ext_lvl  = sync_q[MSB];
  assign ext_rise = ext_lvl & ~last_q;

  generate
    if (HAS_CASCADE) begin : g_casc
      always_comb begin
        unique case (src_e'(src_sel))
          SRC_SYS:        tick = 1'b1;
          SRC_EXT:        tick = ext_rise;
          SRC_CASC:       tick = casc_in;
          SRC_CASC_GATED: tick = casc_in & ext_lvl;
          default:        tick = 1'b0;
        endcase
      end
    end else begin : g_plain
      assign tick = src_sel[0] ? ext_rise : 1'b1;
    end
  endgenerate

  // R11: two edge ticks can never come in back-to-back cycles
  a_r11_edge_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_EXT && tick) |=> (src_sel != SRC_EXT || !tick));
endmodule

// File: rtl/it_core.sv
module it_core
  import it_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic                wr_ctrl,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                tick,
  output logic [2*DATA_W-1:0] cnt_o,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic                uf_o,
  output logic                started_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  latch_q, latch_nxt, cnt_q;
  logic [CTRL_W-1:0] ctrl_q, ctrl_wr;
  logic running, oneshot, uf, load_hi, force_ld, load_any;

  assign running  = ctrl_q[CB_START];
  assign oneshot  = ctrl_q[CB_ONESHOT];
  assign uf       = running & tick & (cnt_q == '0);
  assign load_hi  = wr_hi & (~running | oneshot);
  assign force_ld = wr_ctrl & wdata[CB_LOAD];
  assign load_any = load_hi | force_ld;

  always_comb begin
    latch_nxt = latch_q;
    if (wr_lo) latch_nxt[DATA_W-1:0] = wdata;
    if (wr_hi) latch_nxt[CNT_W-1:DATA_W] = wdata;
    ctrl_wr = wdata[CTRL_W-1:0];
    ctrl_wr[CB_LOAD] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '1;
      cnt_q   <= '1;
      ctrl_q  <= '0;
    end else begin
      latch_q <= latch_nxt;
      if (load_any)             cnt_q <= latch_nxt;
      else if (uf)              cnt_q <= latch_q;
      else if (running && tick) cnt_q <= cnt_q - 1'b1;

      if (wr_ctrl)                ctrl_q <= ctrl_wr;
      else if (wr_hi && oneshot)  ctrl_q[CB_START] <= 1'b1;
      else if (uf && oneshot)     ctrl_q[CB_START] <= 1'b0;
    end
  end

  assign started_o = ~running & ((wr_ctrl & wdata[CB_START]) | (wr_hi & oneshot));
  assign cnt_o  = cnt_q;
  assign ctrl_o = ctrl_q;
  assign uf_o   = uf;

  // R6: reload from the latch after an underflow
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !load_any) |=> (cnt_q == $past(latch_q)));
  // R5: one step down per tick while running
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && cnt_q != '0 && !load_any) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R5: a stopped timer holds its count
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load_any) |=> $stable(cnt_q));
  // R7: one-shot underflow stops the timer
  a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && oneshot && !wr_ctrl && !wr_hi) |=> !ctrl_q[CB_START]);
  // R8: one-shot high write loads and starts
  a_r8_hi_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && oneshot && !wr_ctrl) |=>
      (ctrl_q[CB_START] && cnt_q == {$past(wdata), $past(latch_q[DATA_W-1:0])}));
  // R4: the load strobe is never held
  a_r4_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> !ctrl_q[CB_LOAD]);
endmodule

// File: rtl/it_port_out.sv
module it_port_out (
  input  logic clk,
  input  logic rst_n,
  input  logic uf,
  input  logic started,
  input  logic toggle_form,
  input  logic pb_en,
  output logic irq,
  output logic pb_oe,
  output logic pb_val
);
  logic irq_q, tog_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      irq_q <= uf;
      if (started) tog_q <= 1'b1;
      else if (uf) tog_q <= ~tog_q;
    end
  end

  assign irq    = irq_q;
  assign pb_oe  = pb_en;
  assign pb_val = pb_en & (toggle_form ? tog_q : irq_q);

  // R9: every underflow is followed by a request
  a_r9_irq_after_uf: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> irq);
  // R10: toggle inverts on each underflow that is not a start
  a_r10_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !started) |=> (tog_q != $past(tog_q)));
  // R10: a start drives the toggle high
  a_r10_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> tog_q);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import it_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter bit HAS_CASCADE = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_cnt,
  input  logic              casc_uf,
  output logic              uf_strobe,
  output logic              irq,
  output logic              pb_oe,
  output logic              pb_val
);
  localparam int CNT_W = 2 * DATA_W;

  logic wr, rd, wr_lo, wr_hi, wr_ctrl;
  logic tick, uf, started;
  logic [CNT_W-1:0]  cnt;
  logic [CTRL_W-1:0] ctrl;

  assign wr      = bus_sel & bus_we;
  assign rd      = bus_sel & ~bus_we;
  assign wr_lo   = wr & (bus_addr == REG_LO);
  assign wr_hi   = wr & (bus_addr == REG_HI);
  assign wr_ctrl = wr & (bus_addr == REG_CTRL);

  it_tick_src #(.SYNC_STAGES(SYNC_STAGES), .HAS_CASCADE(HAS_CASCADE)) u_src (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_cnt), .casc_in(casc_uf),
    .src_sel(ctrl[CB_SRC_HI:CB_SRC_LO]), .tick(tick)
  );

  it_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_ctrl(wr_ctrl),
    .wdata(bus_wdata), .tick(tick), .cnt_o(cnt), .ctrl_o(ctrl),
    .uf_o(uf), .started_o(started)
  );

  it_port_out u_out (
    .clk(clk), .rst_n(rst_n), .uf(uf), .started(started),
    .toggle_form(ctrl[CB_TOGGLE]), .pb_en(ctrl[CB_PBEN]),
    .irq(irq), .pb_oe(pb_oe), .pb_val(pb_val)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (reg_e'(bus_addr))
        REG_LO:   bus_rdata = cnt[DATA_W-1:0];
        REG_HI:   bus_rdata = cnt[CNT_W-1:DATA_W];
        REG_CTRL: bus_rdata = DATA_W'(ctrl);
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign uf_strobe = uf;

  // R2: a low-byte write leaves the counter untouched
  a_r2_lo_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !ctrl[CB_START]) |=> $stable(cnt));
  // R3: a high write while running continuous keeps the counter path
  a_r3_run_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && ctrl[CB_START] && !ctrl[CB_ONESHOT] && !tick) |=> $stable(cnt));
endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n = 1'b0, bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic ext_cnt = 1'b0, casc_uf = 1'b0;
  logic uf_strobe, irq, pb_oe, pb_val;

  int errors = 0, checks = 0;

  interval_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_cnt(ext_cnt), .casc_uf(casc_uf), .uf_strobe(uf_strobe),
    .irq(irq), .pb_oe(pb_oe), .pb_val(pb_val)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic t_reset();
    logic [15:0] c; logic [7:0] r;
    rd_cnt(c);          check("R1 counter after reset", c, 16'hFFFF);
    rd(2'd2, r);        check("R1 control after reset", {8'h0, r}, 16'h0000);
    rd(2'd3, r);        check("R2 unused address", {8'h0, r}, 16'h0000);
    check("R1 irq after reset", {15'h0, irq}, 16'h0);
    check("R1 pb_oe after reset", {15'h0, pb_oe}, 16'h0);
    check("R1 pb_val after reset", {15'h0, pb_val}, 16'h0);
  endtask

  task automatic t_load();
    logic [15:0] c;
    wr(2'd1, 8'h12);
    rd_cnt(c); check("R3 stopped high write loads (R1 latch low FF)", c, 16'h12FF);
    wr(2'd0, 8'h34);
    rd_cnt(c); check("R2 low write leaves counter", c, 16'h12FF);
  endtask

  task automatic t_force();
    logic [15:0] c; logic [7:0] r;
    wr(2'd2, 8'h00);
    rd_cnt(c); check("R4 writing 0 to load bit", c, 16'h12FF);
    wr(2'd2, 8'h10);
    rd_cnt(c); check("R4 force load", c, 16'h1234);
    rd(2'd2, r); check("R4 load bit reads 0", {8'h0, r}, 16'h0000);
  endtask

  task automatic t_continuous();
    logic [15:0] c, c2; int e; logic exp_uf;
    wr(2'd0, 8'h03); wr(2'd1, 8'h00);
    wr(2'd2, 8'h03);
    rd_cnt(c); check("R5 count at start", c, 16'h0003);
    check("R10 pb_oe follows bit 1", {15'h0, pb_oe}, 16'h1);
    e = 3;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      exp_uf = (e == 0);
      e = exp_uf ? 3 : e - 1;
      rd_cnt(c);
      check("R5 R6 continuous count", c, 16'(e));
      check("R6 uf_strobe", {15'h0, uf_strobe}, {15'h0, e == 0});
      check("R9 irq one cycle after underflow", {15'h0, irq}, {15'h0, exp_uf});
      check("R10 pulse form pb_val", {15'h0, pb_val}, {15'h0, exp_uf});
    end
    wr(2'd2, 8'h02);
    rd_cnt(c);
    repeat (3) @(negedge clk);
    rd_cnt(c2); check("R5 stopped counter holds", c2, c);
  endtask

  task automatic t_running_hi();
    logic [15:0] c;
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h50);
    wr(2'd1, 8'h01);
    rd_cnt(c); check("R3 running high write keeps counter", {8'h0, c[15:8]}, 16'h0000);
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h10);
    rd_cnt(c); check("R3 latch took the running write", c, 16'h0150);
  endtask

  task automatic t_oneshot();
    logic [15:0] c; logic [7:0] r;
    wr(2'd0, 8'h02); wr(2'd1, 8'h00);
    wr(2'd2, 8'h0F);
    rd_cnt(c); check("R7 one-shot start value", c, 16'h0002);
    check("R10 toggle high on start", {15'h0, pb_val}, 16'h1);
    @(negedge clk); rd_cnt(c); check("R7 one-shot count", c, 16'h0001);
    @(negedge clk); rd_cnt(c); check("R7 one-shot zero", c, 16'h0000);
    check("R6 one-shot uf_strobe", {15'h0, uf_strobe}, 16'h1);
    @(negedge clk); rd_cnt(c); check("R7 reload", c, 16'h0002);
    rd(2'd2, r); check("R7 start bit cleared", {8'h0, r}, 16'h000E);
    check("R10 toggle inverted", {15'h0, pb_val}, 16'h0);
    check("R9 irq one-shot", {15'h0, irq}, 16'h1);
    repeat (2) @(negedge clk);
    rd_cnt(c); check("R7 stays stopped", c, 16'h0002);
    check("R9 irq single cycle", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_oneshot_hi();
    logic [15:0] c; logic [7:0] r;
    wr(2'd1, 8'h00);
    rd(2'd2, r); check("R8 high write sets start", {8'h0, r}, 16'h000F);
    rd_cnt(c); check("R8 high write loads", c, 16'h0002);
    check("R10 toggle high on restart", {15'h0, pb_val}, 16'h1);
    repeat (3) @(negedge clk);
    rd_cnt(c); check("R8 ran to reload", c, 16'h0002);
    rd(2'd2, r); check("R8 stopped again", {8'h0, r}, 16'h000E);
  endtask

  task automatic t_ext();
    logic [15:0] c;
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h05); wr(2'd1, 8'h00);
    wr(2'd2, 8'h21);
    repeat (6) @(negedge clk);
    rd_cnt(c); check("R11 low level no ticks", c, 16'h0005);
    for (int i = 0; i < 2; i++) begin
      ext_cnt = 1'b1; repeat (4) @(negedge clk);
      ext_cnt = 1'b0; repeat (4) @(negedge clk);
    end
    rd_cnt(c); check("R11 two edges two ticks", c, 16'h0003);
    ext_cnt = 1'b1; repeat (10) @(negedge clk);
    rd_cnt(c); check("R11 high level one tick", c, 16'h0002);
    ext_cnt = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic casc_pulse();
    @(negedge clk); casc_uf = 1'b1;
    @(negedge clk); casc_uf = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_casc();
    logic [15:0] c;
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h41);
    casc_pulse(); casc_pulse();
    rd_cnt(c); check("R12 companion ticks", c, 16'h0003);
    wr(2'd2, 8'h61);
    casc_pulse(); casc_pulse();
    rd_cnt(c); check("R12 gated with ext low", c, 16'h0003);
    ext_cnt = 1'b1; repeat (4) @(negedge clk);
    casc_pulse();
    rd_cnt(c); check("R12 gated with ext high", c, 16'h0002);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_force();
    t_continuous();
    t_running_hi();
    t_oneshot();
    t_oneshot_hi();
    t_ext();
    t_casc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule